// File: doc/BRIEF.md
# Asynchronous SRAM strobe sequencer

This block sits between a synchronous host and an external asynchronous static RAM with an 18-bit word address and a byte-wide data bus. A single-beat request (read or write) is accepted through a valid/ready handshake. The block then plays out the chip-select, write-strobe and output-strobe sequence that the RAM needs, with every phase long enough for its access, pulse-width, setup and bus-turnaround limits. The RAM has an active-low select and an active-high select. Both are used, and both are dropped whenever the RAM is not being accessed.

All timing limits are given as nanosecond parameters. Each one is turned into a whole number of clock cycles by rounding up against the clock-period parameter, so the same code covers slow and fast RAM speed grades. With the defaults (10 ns clock, 55 ns grade), a request uses one cycle of address setup. A read then holds the RAM selected with output strobe low for 6 cycles. A write holds the write strobe low for 6 cycles, with the block's data drivers off for the first 2 of them, and adds 1 cycle of data hold.

Back-pressure: `req_ready` is high only when the block is idle. A request is taken on the clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the request inputs are ignored. Read data comes back as a one-cycle `rsp_valid` pulse that has no back-pressure. Writes return no response; the return of `req_ready` marks their completion.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset and whenever idle, the RAM is deselected: `mem_ce_n`=1, `mem_ce2`=0, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0.
- R2: `mem_addr` changes only on edges where the RAM is deselected (`mem_ce_n`=1 or `mem_ce2`=0) in the cycles on both sides of the change, and it holds the accepted address throughout the access.
- R3: `req_ready` drops on the edge after acceptance and stays low for the whole access: 7 cycles for a read and 8 for a write with the defaults. Request inputs that change while it is low have no effect on `mem_addr` or `mem_dq_out`.
- R4: A read keeps the RAM selected with `mem_oe_n`=0 and `mem_we_n`=1 for max(ceil(tAA), ceil(tOE), ceil(tRC)) cycles (6 by default). `mem_dq_in` is captured on the last edge of that window. `rsp_valid` is high for exactly one cycle, in the cycle when `req_ready` returns, and `rsp_rdata` carries the captured byte.
- R5: A write drives `mem_we_n`=0 while the RAM is selected for max(ceil(tWP), ceil(tAW), ceil(tRC), Z+ceil(tDW)) cycles (6 by default), where Z is the larger of the write-to-high-Z and release times in cycles. `mem_oe_n` stays 1 throughout the write.
- R6: During the write pulse, `mem_dq_oe` is 0 for the first Z cycles (2 by default) and 1 for the rest. It stays 1 for exactly one cycle after `mem_we_n` rises and is then 0. While it is 1, `mem_dq_out` equals the accepted write data, so the byte is committed.
- R7: `mem_dq_oe` is never 1 while `mem_oe_n` is 0, nor within Z cycles after `mem_oe_n` rises. This covers a write that follows a read back to back.
- R8: A write produces no `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 18 | RAM address |
| mem_ce_n | output | 1 | RAM select, active low |
| mem_ce2 | output | 1 | RAM select, active high |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output strobe, active low |
| mem_dq_out | output | 8 | Data toward the RAM |
| mem_dq_in | input | 8 | Data from the RAM |
| mem_dq_oe | output | 1 | Enable of the block's data drivers |

## Verification
The hardest case to reach is a write that starts on the first idle cycle after a read. Only then does the RAM's output-release window overlap the write's turnaround gap. The bench raises the write request on the same sample in which `req_ready` returns from a read. Its RAM model keeps a tail counter that shows when the RAM could still be driving, and the bench counts any cycle in which the block's drivers are on during that tail. A second hard case is an input change during a busy access. The bench flips the address, data and write flag right after acceptance and checks that the RAM-side address and data stay unchanged.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_READ,
    PH_WRITE,
    PH_HOLD
  } phase_e;

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned LS    = 1,
  parameter int unsigned LR    = 6,
  parameter int unsigned LW    = 6,
  parameter int unsigned LZ    = 2,
  parameter int unsigned LH    = 1,
  parameter int unsigned CNT_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic cap_req,
  output logic cap_rd,
  output logic mem_ce_n,
  output logic mem_ce2,
  output logic mem_we_n,
  output logic mem_oe_n,
  output logic mem_dq_oe
);

  localparam logic [CNT_W-1:0] LS_M1    = CNT_W'(LS - 1);
  localparam logic [CNT_W-1:0] LR_M1    = CNT_W'(LR - 1);
  localparam logic [CNT_W-1:0] LW_M1    = CNT_W'(LW - 1);
  localparam logic [CNT_W-1:0] LH_M1    = CNT_W'(LH - 1);
  localparam logic [CNT_W-1:0] DRV_FROM = CNT_W'(LW - 1 - LZ);

  phase_e           phase, phase_nxt;
  logic             is_wr;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic [CNT_W-1:0] tmr_cnt;
  logic             tmr_done;
  logic             sel;

  sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .cnt      (tmr_cnt),
    .done     (tmr_done)
  );

  always_comb begin
    phase_nxt = phase;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    unique case (phase)
      PH_IDLE: if (req_valid) begin
        phase_nxt = PH_SETUP;
        tmr_load  = 1'b1;
        tmr_val   = LS_M1;
      end
      PH_SETUP: if (tmr_done) begin
        phase_nxt = is_wr ? PH_WRITE : PH_READ;
        tmr_load  = 1'b1;
        tmr_val   = is_wr ? LW_M1 : LR_M1;
      end
      PH_READ: if (tmr_done) phase_nxt = PH_IDLE;
      PH_WRITE: if (tmr_done) begin
        phase_nxt = PH_HOLD;
        tmr_load  = 1'b1;
        tmr_val   = LH_M1;
      end
      PH_HOLD: if (tmr_done) phase_nxt = PH_IDLE;
      default: phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      is_wr <= 1'b0;
    end else begin
      phase <= phase_nxt;
      if (cap_req) is_wr <= req_write;
    end
  end

  assign req_ready = (phase == PH_IDLE);
  assign cap_req   = req_ready && req_valid;
  assign cap_rd    = (phase == PH_READ) && tmr_done;

  assign sel       = (phase == PH_READ) || (phase == PH_WRITE);
  assign mem_ce_n  = !sel;
  assign mem_ce2   = sel;
  assign mem_we_n  = (phase != PH_WRITE);
  assign mem_oe_n  = (phase != PH_READ);
  assign mem_dq_oe = ((phase == PH_WRITE) && (tmr_cnt <= DRV_FROM)) ||
                     ((phase == PH_HOLD) && (tmr_cnt == LH_M1));

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R3

  AST_IDLE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    cap_rd |=> (req_ready && mem_ce_n && !mem_ce2 && mem_oe_n)); // R1

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_req,
  input  logic              cap_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      if (cap_req) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      rsp_valid <= cap_rd;
      if (cap_rd) rsp_rdata <= mem_dq_in;
    end
  end

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R4

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CLK_NS   = 10,
  parameter int unsigned T_RC_NS  = 55,
  parameter int unsigned T_AA_NS  = 55,
  parameter int unsigned T_OE_NS  = 30,
  parameter int unsigned T_WP_NS  = 45,
  parameter int unsigned T_DW_NS  = 25,
  parameter int unsigned T_AW_NS  = 50,
  parameter int unsigned T_WHZ_NS = 20,
  parameter int unsigned T_HZ_NS  = 20,
  parameter int unsigned T_AS_NS  = 0,
  parameter int unsigned T_WR_NS  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  localparam int unsigned LS    = max2(1, ns_to_cyc(T_AS_NS, CLK_NS));
  localparam int unsigned LR    = max2(max2(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS)),
                                       ns_to_cyc(T_RC_NS, CLK_NS));
  localparam int unsigned LZ    = max2(ns_to_cyc(T_WHZ_NS, CLK_NS), ns_to_cyc(T_HZ_NS, CLK_NS));
  localparam int unsigned LW    = max2(max2(ns_to_cyc(T_WP_NS, CLK_NS), LZ + max2(1, ns_to_cyc(T_DW_NS, CLK_NS))),
                                       max2(ns_to_cyc(T_AW_NS, CLK_NS), ns_to_cyc(T_RC_NS, CLK_NS)));
  localparam int unsigned LH    = max2(1, ns_to_cyc(T_WR_NS, CLK_NS));
  localparam int unsigned LMAX  = max2(max2(LR, LW), max2(LS, LH));
  localparam int unsigned CNT_W = $clog2(LMAX + 1);
  localparam int unsigned QW    = $clog2(LZ + 2);
  localparam int unsigned WW    = $clog2(LW + 2);

  logic cap_req;
  logic cap_rd;

  sram_seq_fsm #(
    .LS(LS), .LR(LR), .LW(LW), .LZ(LZ), .LH(LH), .CNT_W(CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .cap_req   (cap_req),
    .cap_rd    (cap_rd),
    .mem_ce_n  (mem_ce_n),
    .mem_ce2   (mem_ce2),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
  );

  sram_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_req    (cap_req),
    .cap_rd     (cap_rd),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  // cycles since the RAM output strobe was released, saturating at LZ
  logic [QW-1:0] oe_quiet;
  // length of the current write-strobe low stretch, saturating at LW
  logic [WW-1:0] we_low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_quiet <= '0;
      we_low   <= '0;
    end else begin
      if (!mem_oe_n)                oe_quiet <= '0;
      else if (oe_quiet != QW'(LZ)) oe_quiet <= oe_quiet + 1'b1;
      if (mem_we_n)                 we_low   <= '0;
      else if (we_low != WW'(LW))   we_low   <= we_low + 1'b1;
    end
  end

  AST_ADDR_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> (mem_ce_n || !mem_ce2)); // R2

  AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n && mem_ce2)); // R5

  AST_WE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low >= WW'(LW))); // R5

  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && (oe_quiet >= QW'(LZ)))); // R7

  AST_WRITE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !rsp_valid); // R8

endmodule

// File: tb/sim_sram_strobe_ctrl.sv
module sim_sram_strobe_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [17:0] mem_addr;
  logic        mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_strobe_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  // RAM model: 256 bytes indexed by the low address byte
  logic [7:0]  ram [256];
  logic        sel_m;
  logic        wr_act = 1'b0;
  logic [17:0] wr_a = '0;
  logic [7:0]  wr_d = '0;
  int          rd_tail = 0;
  int          fights = 0;
  int          addr_viol = 0;
  logic [17:0] prev_addr = '0;
  logic        prev_sel = 1'b0;

  assign sel_m     = !mem_ce_n && mem_ce2;
  assign mem_dq_in = (sel_m && !mem_oe_n && mem_we_n) ? ram[mem_addr[7:0]] : 8'h00;

  initial for (int i = 0; i < 256; i++) ram[i] = 8'h00;

  always @(posedge clk) begin
    if (sel_m && !mem_we_n) begin
      wr_act <= 1'b1;
      wr_a   <= mem_addr;
      wr_d   <= mem_dq_oe ? mem_dq_out : 8'hEE;
    end else if (wr_act) begin
      ram[wr_a[7:0]] <= wr_d;
      wr_act <= 1'b0;
    end
    if (sel_m && !mem_oe_n) rd_tail <= 2;
    else if (rd_tail != 0)  rd_tail <= rd_tail - 1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_dq_oe && ((sel_m && !mem_oe_n) || rd_tail != 0)) fights++;
      if (mem_addr != prev_addr && (sel_m || prev_sel)) addr_viol++;
    end
    prev_addr = mem_addr;
    prev_sel  = sel_m;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(mem_ce_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready, req,
        {mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 6'b101101);
  endtask

  // called at a negedge where req_ready is high
  task automatic do_write(input logic [17:0] a, input logic [7:0] d, input bit scramble);
    int busy = 0, we_lo = 0, drv = 0, early = 0, hold_drv = 0;
    int oe_bad = 0, dat_bad = 0, adr_bad = 0, rsp_n = 0;
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (scramble) begin req_addr = ~a; req_wdata = ~d; req_write = 1'b0; end
    while (!req_ready && busy < 60) begin
      busy++;
      if (!mem_we_n) begin
        we_lo++;
        if (mem_dq_oe) begin drv++; if (we_lo <= 2) early++; end
      end else if (mem_dq_oe) hold_drv++;
      if (!mem_oe_n) oe_bad++;
      if (mem_dq_oe && mem_dq_out != d) dat_bad++;
      if (mem_addr != a) adr_bad++;
      if (rsp_valid) rsp_n++;
      @(negedge clk);
    end
    chk(busy == 8, "R3 write busy cycles", busy, 8);
    chk(we_lo == 6, "R5 write pulse cycles", we_lo, 6);
    chk(oe_bad == 0, "R5 oe low during write", oe_bad, 0);
    chk(early == 0 && drv == 4, "R6 driver gap in pulse", drv, 4);
    chk(hold_drv == 1, "R6 driver hold cycles", hold_drv, 1);
    chk(dat_bad == 0, "R6 write data on bus", dat_bad, 0);
    chk(adr_bad == 0, scramble ? "R3 busy inputs ignored (addr)" : "R2 address held", adr_bad, 0);
    chk(rsp_n == 0, "R8 no response for write", rsp_n, 0);
    chk_idle("R1 idle after write");
  endtask

  task automatic do_read(input logic [17:0] a, input logic [7:0] exp);
    int busy = 0, oe_lo = 0, we_bad = 0, adr_bad = 0, early_rsp = 0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = 8'h5A;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready && busy < 60) begin
      busy++;
      if (!mem_oe_n) begin
        oe_lo++;
        if (mem_ce_n || !mem_ce2) we_bad++;
      end
      if (!mem_we_n) we_bad++;
      if (sel_m && mem_addr != a) adr_bad++;
      if (rsp_valid) early_rsp++;
      @(negedge clk);
    end
    chk(busy == 7, "R3 read busy cycles", busy, 7);
    chk(oe_lo == 6, "R4 read strobe cycles", oe_lo, 6);
    chk(we_bad == 0, "R4 read strobe levels", we_bad, 0);
    chk(adr_bad == 0, "R2 address held in read", adr_bad, 0);
    chk(early_rsp == 0 && rsp_valid, "R4 response timing", rsp_valid, 1);
    chk(rsp_rdata == exp, "R4 read data", rsp_rdata, exp);
    chk_idle("R1 idle after read");
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    chk_idle("R1 reset state");
    chk(!rsp_valid, "R4 no response at reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 idle after reset release");
  endtask

  task automatic test_basic();
    do_write(18'h00012, 8'hA5, 1'b0);
    @(negedge clk);
    do_read(18'h00012, 8'hA5);
  endtask

  task automatic test_patterns();
    do_write(18'h3FFFF, 8'hFF, 1'b0);
    do_write(18'h00000, 8'h00, 1'b0);
    do_write(18'h2AA55, 8'h3C, 1'b0);
    do_read(18'h3FFFF, 8'hFF);
    do_read(18'h00000, 8'h00);
    do_read(18'h2AA55, 8'h3C);
  endtask

  task automatic test_read_then_write();
    // write issued on the very sample where the read hands back ready (R7)
    do_read(18'h00012, 8'hA5);
    do_write(18'h00034, 8'hC3, 1'b0);
    do_read(18'h00034, 8'hC3);
  endtask

  task automatic test_busy_ignore();
    do_write(18'h00077, 8'h81, 1'b1);
    chk(mem_addr == 18'h00077, "R3 ignored inputs leave address", mem_addr, 18'h00077);
    do_read(18'h00077, 8'h81);
  endtask

  task automatic test_monitors();
    @(negedge clk);
    chk(fights == 0, "R7 bus fight cycles", fights, 0);
    chk(addr_viol == 0, "R2 address change while selected", addr_viol, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    test_reset();
    test_basic();
    test_patterns();
    test_read_then_write();
    test_busy_ignore();
    test_monitors();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule